// File: doc/BRIEF.md
# Cascadable Configuration Memory Streamer

This block models a read-only configuration store that feeds its contents to a loading device over a shared clock. Each rising clock edge places the next stored item on the data lines. In byte mode the item is a whole byte on `data_o[7:0]`. In serial mode it is one bit on `data_o[0]`, taken from the most significant bit of each byte first. The item stays on the lines until the following rising edge, so the loader captures it on that edge.

The store is a small ROM built from a parameter vector. Byte `k` sits at bits `[8k+7:8k]`. An active-low chip enable and a combined output-enable/reset input both gate the device. When the store is used up, the device stops driving and pulls its cascade-enable output low. That output feeds the chip enable of the next device in a chain, and all devices in the chain share the clock and data lines. Byte mode keeps no length count, so the clock may run on indefinitely after the end; the device then stays quiet and never wraps. The bus is modelled with an explicit drive flag (`drive_o`) in place of high impedance, and `data_o` reads zero whenever the flag is low.

Top module: `cfg_stream_mem`

## Requirements
- R1: While `rst_ni` is low, `drive_o` is 0, `data_o` is 0 and `ceo_no` is 1. After release, the first enabled edge presents the first item of byte 0.
- R2: With `byte_mode_i`=1, each rising edge with `ce_ni`=0 and `oe_rst_i`=1 presents the next stored byte on `data_o[7:0]` with `drive_o`=1, starting from byte 0.
- R3: With `byte_mode_i`=0, each enabled edge presents the next bit on `data_o[0]` with `data_o[7:1]`=0. Bits leave each byte starting at bit 7, and the byte address advances after bit 0.
- R4: While `ce_ni` is 1, `drive_o` and `data_o` are 0 at once and the read position holds. When `ce_ni` returns to 0, the stream resumes with the first item not yet presented.
- R5: While `oe_rst_i` is 0, `drive_o` is 0 at once. A rising edge with `oe_rst_i`=0 returns the read position to byte 0, bit 7, and sets `ceo_no` to 1. The next enabled edge presents the first item again.
- R6: The first enabled edge after the last item was presented sets `drive_o` to 0 and `ceo_no` to 0. Further clock edges keep both values, and the stream does not wrap.
- R7: `ceo_no` is 0 only while `ce_ni` is 0 and the contents are used up. Raising `ce_ni` returns `ceo_no` to 1.
- R8: In a chain where `ceo_no` of one device drives `ce_ni` of the next, the two devices never drive at the same time. The second device presents its byte 0 on the second edge after the first device's last byte, which leaves one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock, rising edge |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_rst_i | input | 1 | Output enable when high; synchronous reset of the read position when low |
| byte_mode_i | input | 1 | 1 = one byte per edge, 0 = one bit per edge |
| data_o | output | 8 | Data lines; bit 0 alone carries data in serial mode |
| drive_o | output | 1 | High while the device owns the shared data lines |
| ceo_no | output | 1 | Cascade enable to the next device, active low |

## Verification
The bench builds two instances with different contents. `u0` holds five bytes, which makes a full serial pass 40 bits long, so the byte-address rollover and the end of the store are reached many times under random chip-enable gaps. `u1` holds three bytes and takes its chip enable from the cascade output of `u0`. This brings the handoff, the one-cycle idle gap and the bus ownership between the two devices within reach. Random runs in both modes are mixed with directed resets in the middle of a stream and long free-running clocks past the end.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

  typedef enum logic {
    MODE_SERIAL = 1'b0,
    MODE_BYTE   = 1'b1
  } rd_mode_e;

  typedef struct packed {
    logic [2:0] bit_sel;
    logic       step;
    logic       last_bit;
  } seq_ctl_t;

  function automatic logic [7:0] pick_msb_first(input logic [7:0] b, input logic [2:0] sel);
    return {7'b0, b[3'd7 - sel]};
  endfunction

endpackage

// File: rtl/cfg_image_rom.sv
module cfg_image_rom #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = $clog2(DEPTH + 1),
  parameter logic [DEPTH*8-1:0] INIT = {DEPTH{8'h96}}
) (
  input  logic [AW-1:0] addr_i,
  output logic [7:0]    byte_o
);

  logic [7:0] rom_arr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign rom_arr[g] = INIT[g*8 +: 8];
  end

  always_comb begin
    byte_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (addr_i == AW'(k)) byte_o = rom_arr[k];
    end
  end

endmodule

// File: rtl/cfg_read_seq.sv
module cfg_read_seq
  import cfg_stream_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_rst_i,
  input  logic          byte_mode_i,
  output logic [AW-1:0] addr_o,
  output logic [2:0]    bit_o,
  output logic          load_o,
  output logic          done_o
);

  localparam logic [AW-1:0] END_A = AW'(DEPTH);

  logic [AW-1:0] addr_q;
  logic [2:0]    bit_q;
  logic          done_q;
  logic          active;
  rd_mode_e      mode;

  assign mode   = rd_mode_e'(byte_mode_i);
  assign active = !ce_ni && oe_rst_i && !done_q;
  assign load_o = active && (addr_q != END_A);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else if (!oe_rst_i) begin
      addr_q <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else if (active) begin
      if (addr_q == END_A) begin
        done_q <= 1'b1;
      end else if (mode == MODE_BYTE) begin
        addr_q <= addr_q + 1'b1;
        bit_q  <= '0;
      end else begin
        bit_q <= bit_q + 1'b1;
        if (bit_q == 3'd7) addr_q <= addr_q + 1'b1;
      end
    end
  end

  assign addr_o = addr_q;
  assign bit_o  = bit_q;
  assign done_o = done_q;

  AST_NO_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_q <= END_A); // R6
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && oe_rst_i |=> done_q); // R6
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni && oe_rst_i |=> $stable(addr_q) && $stable(bit_q)); // R4
  AST_REWIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_rst_i |=> addr_q == '0 && bit_q == '0 && !done_q); // R5
  AST_BYTE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o && byte_mode_i |=> addr_q == $past(addr_q) + 1'b1); // R2

endmodule

// File: rtl/cfg_out_stage.sv
module cfg_out_stage
  import cfg_stream_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_ni,
  input  logic       oe_rst_i,
  input  logic       load_i,
  input  logic       byte_mode_i,
  input  logic [7:0] byte_i,
  input  logic [2:0] bit_sel_i,
  output logic [7:0] data_o,
  output logic       drive_o
);

  logic [7:0] data_q;
  logic       vld_q;
  logic       mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      vld_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      vld_q <= load_i;
      if (load_i) begin
        mode_q <= byte_mode_i;
        data_q <= byte_mode_i ? byte_i : pick_msb_first(byte_i, bit_sel_i);
      end
    end
  end

  // item stays on the lines until the next edge; gates cut the drive at once
  assign drive_o = vld_q && !ce_ni && oe_rst_i;
  assign data_o  = drive_o ? data_q : '0;

  AST_SERIAL_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o && !mode_q |-> data_o[7:1] == '0); // R3
  AST_NO_LOAD_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> !drive_o); // R4

endmodule

// File: rtl/cfg_stream_mem.sv
module cfg_stream_mem #(
  parameter int unsigned DEPTH = 16,
  parameter logic [DEPTH*8-1:0] INIT = {DEPTH{8'h96}}
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_ni,
  input  logic       oe_rst_i,
  input  logic       byte_mode_i,
  output logic [7:0] data_o,
  output logic       drive_o,
  output logic       ceo_no
);

  localparam int unsigned AW = $clog2(DEPTH + 1);

  logic [AW-1:0] addr;
  logic [2:0]    bit_sel;
  logic          load;
  logic          done;
  logic [7:0]    rom_byte;

  cfg_read_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_ni       (ce_ni),
    .oe_rst_i    (oe_rst_i),
    .byte_mode_i (byte_mode_i),
    .addr_o      (addr),
    .bit_o       (bit_sel),
    .load_o      (load),
    .done_o      (done)
  );

  cfg_image_rom #(.DEPTH(DEPTH), .AW(AW), .INIT(INIT)) u_rom (
    .addr_i (addr),
    .byte_o (rom_byte)
  );

  cfg_out_stage u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_ni       (ce_ni),
    .oe_rst_i    (oe_rst_i),
    .load_i      (load),
    .byte_mode_i (byte_mode_i),
    .byte_i      (rom_byte),
    .bit_sel_i   (bit_sel),
    .data_o      (data_o),
    .drive_o     (drive_o)
  );

  assign ceo_no = !(done && !ce_ni);

  AST_HANDOFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ceo_no |-> !drive_o); // R6
  AST_CEO_NEEDS_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> ceo_no); // R7

endmodule

// File: tb/sim_cfg_stream_mem.sv
module sim_cfg_stream_mem;

  localparam int CLK_P = 10;
  localparam int D0 = 5;
  localparam int D1 = 3;

  function automatic logic [7:0] b0(input int i);
    return 8'((i * 53 + 29) ^ (i << 4));
  endfunction
  function automatic logic [7:0] b1(input int i);
    return 8'((i * 91 + 7) ^ 8'hC3);
  endfunction
  function automatic logic [D0*8-1:0] img0();
    logic [D0*8-1:0] v;
    for (int i = 0; i < D0; i++) v[i*8 +: 8] = b0(i);
    return v;
  endfunction
  function automatic logic [D1*8-1:0] img1();
    logic [D1*8-1:0] v;
    for (int i = 0; i < D1; i++) v[i*8 +: 8] = b1(i);
    return v;
  endfunction
  function automatic logic [7:0] serial_item(input int idx);
    logic [7:0] b;
    b = b0(idx / 8);
    return {7'b0, b[7 - (idx % 8)]};
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce0_n = 1'b1;
  logic oe0 = 1'b1;
  logic oe1 = 1'b0;
  logic mode = 1'b1;
  logic [7:0] d0, d1;
  logic drv0, drv1, ceo0_n, ceo1_n;

  int checks = 0;
  int errors = 0;

  always #(CLK_P / 2) clk = ~clk;

  cfg_stream_mem #(.DEPTH(D0), .INIT(img0())) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce0_n), .oe_rst_i(oe0),
    .byte_mode_i(mode), .data_o(d0), .drive_o(drv0), .ceo_no(ceo0_n)
  );

  cfg_stream_mem #(.DEPTH(D1), .INIT(img1())) u1 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ceo0_n), .oe_rst_i(oe1),
    .byte_mode_i(mode), .data_o(d1), .drive_o(drv1), .ceo_no(ceo1_n)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rewind();
    oe0 = 1'b0;
    cyc();
    oe0 = 1'b1;
  endtask

  task automatic run_stream(input bit m, input int gap_pct);
    int total;
    int idx;
    int done_seen;
    logic [7:0] exp;
    total = m ? D0 : D0 * 8;
    idx = 0;
    done_seen = 0;
    mode = m;
    rewind();
    while (done_seen < 4) begin
      ce0_n = (($urandom % 100) < gap_pct);
      cyc();
      if (ce0_n) begin
        chk(drv0 == 1'b0 && d0 == 8'h00, "R4", "gated drive/data", {drv0, d0}, 0);
        chk(ceo0_n == 1'b1, "R7", "ceo while ce high", ceo0_n, 1);
      end else if (idx < total) begin
        exp = m ? b0(idx) : serial_item(idx);
        chk(drv0 == 1'b1 && d0 == exp, m ? "R2" : "R3", "stream item", {drv0, d0}, {1'b1, exp});
        idx++;
      end else begin
        chk(drv0 == 1'b0 && ceo0_n == 1'b0, "R6", "end of store", {drv0, ceo0_n}, 0);
        done_seen++;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    @(negedge clk);
    // R1 reset state
    chk(drv0 == 1'b0 && d0 == 8'h00 && ceo0_n == 1'b1, "R1", "reset outputs", {drv0, d0, ceo0_n}, 1);
    cyc();
    rst_n = 1'b1;
    ce0_n = 1'b0;
    mode = 1'b1;
    cyc();
    chk(drv0 == 1'b1 && d0 == b0(0), "R1", "first byte after reset", d0, b0(0));

    // R2 byte mode, no gaps, then free run past end (R6)
    run_stream(1'b1, 0);
    repeat (20) cyc();
    chk(drv0 == 1'b0 && ceo0_n == 1'b0, "R6", "no wrap after long free run", {drv0, ceo0_n}, 0);
    ce0_n = 1'b1;
    #1;
    chk(ceo0_n == 1'b1, "R7", "ceo released by ce high", ceo0_n, 1);
    ce0_n = 1'b0;

    // R3 serial full pass, then random gaps in both modes (R4)
    run_stream(1'b0, 0);
    for (int r = 0; r < 6; r++) begin
      run_stream(1'b0, 30);
      run_stream(1'b1, 40);
    end

    // R5 rewind in the middle of a serial stream
    mode = 1'b0;
    ce0_n = 1'b0;
    rewind();
    repeat (11) cyc();
    chk(drv0 == 1'b1 && d0 == serial_item(10), "R3", "serial item 10", d0, serial_item(10));
    oe0 = 1'b0;
    #1;
    chk(drv0 == 1'b0 && d0 == 8'h00, "R5", "drive cut by oe low", {drv0, d0}, 0);
    cyc();
    oe0 = 1'b1;
    chk(ceo0_n == 1'b1, "R5", "ceo high after rewind", ceo0_n, 1);
    cyc();
    chk(drv0 == 1'b1 && d0 == serial_item(0), "R5", "restart at first bit", d0, serial_item(0));

    // R5 rewind after end in byte mode
    mode = 1'b1;
    rewind();
    repeat (D0 + 1) cyc();
    chk(ceo0_n == 1'b0, "R6", "done before rewind", ceo0_n, 0);
    rewind();
    chk(ceo0_n == 1'b1, "R5", "ceo cleared by rewind", ceo0_n, 1);
    cyc();
    chk(d0 == b0(0) && drv0 == 1'b1, "R5", "byte 0 after rewind", d0, b0(0));

    // R8 two-device chain on shared lines
    ce0_n = 1'b0;
    oe0 = 1'b0;
    oe1 = 1'b0;
    cyc();
    oe0 = 1'b1;
    oe1 = 1'b1;
    for (int c = 1; c <= D0 + D1 + 4; c++) begin
      logic [7:0] bus;
      logic [7:0] expb;
      logic expd;
      cyc();
      bus = drv0 ? d0 : (drv1 ? d1 : 8'h00);
      chk(!(drv0 && drv1), "R8", "single driver", {drv0, drv1}, 0);
      if (c <= D0) begin expd = 1'b1; expb = b0(c - 1); end
      else if (c == D0 + 1) begin expd = 1'b0; expb = 8'h00; end
      else if (c <= D0 + 1 + D1) begin expd = 1'b1; expb = b1(c - D0 - 2); end
      else begin expd = 1'b0; expb = 8'h00; end
      chk((drv0 || drv1) == expd && bus == expb, "R8", "chain bus", {drv0 || drv1, bus}, {expd, expb});
    end
    chk(ceo1_n == 1'b0, "R8", "second device handed off", ceo1_n, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule